// File: doc/BRIEF.md
# Narrow-to-Wide Memory Lane Adapter

This block gives its user a narrow, deep memory with one write port and one read port. The storage behind it is a wider and shallower array. Each wide row holds several narrow entries, and each entry sits in its own lane.

An incoming narrow address splits into two parts. The low bits choose a lane inside the wide row, and the remaining upper bits choose the row. A write zero-extends the narrow data and shifts it into the chosen lane. It also drives a one-hot lane mask, so that only that lane of the row is updated. A read fetches the whole row into a register and keeps the lane index that arrived with it. The narrow output is then cut out of that registered row.

The write port and the read port each have their own clock. The wide masked array is modelled behaviourally inside the block. The default shape stores a 2-bit by 256-entry memory as an 8-bit by 64-row array, with four 2-bit lanes.

Top module: `lane_fold_mem`

## Requirements
- R1: With LANES = WIDE_W / NARROW_W, the narrow address `a` maps to row `a >> log2(LANES)` and lane `a % LANES`. Every one of the NARROW_DEPTH addresses holds its own independent value.
- R2: A write updates only the addressed lane. The other lanes of the same row keep their contents, even when writes to different lanes of one row come back to back. The internal lane mask has exactly one bit set during a write.
- R3: Data written to lane `k` occupies bits `[NARROW_W*(k+1)-1 : NARROW_W*k]` of the wide row. It reads back unchanged from the same narrow address.
- R4: When `rd_en` is high at a `rd_clk` edge, `rd_data` presents the value stored at `rd_addr` from that edge until the next read.
- R5: While `rd_en` is low, `rd_data` holds its value. This holds even if `rd_addr` changes or the held address is rewritten.
- R6: When `wr_en` is low at a `wr_clk` edge, no storage is changed, whatever `wr_addr` and `wr_data` carry.
- R7: A synchronous active-high `rst` sampled on `rd_clk` clears `rd_data` to zero. It does not alter the stored contents.
- R8: When a read and a write to the same address fall on the same edge of a shared clock, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write enable |
| wr_addr | input | log2(NARROW_DEPTH) | Narrow write address |
| wr_data | input | NARROW_W | Narrow write data |
| rd_clk | input | 1 | Read port clock |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| rd_en | input | 1 | Read enable |
| rd_addr | input | log2(NARROW_DEPTH) | Narrow read address |
| rd_data | output | NARROW_W | Narrow read data, one edge after a read |

## Verification
Several internal faults all surface at the read port. A wrong row or lane split, a mask with more than one bit, or data shifted by the wrong amount each corrupt a neighbouring entry or return a wrong value. The error appears on the first read of an affected address, one `rd_clk` edge after that read is issued. A lane register that is out of step with the registered row produces a wrong value from that same edge. A register that updates without `rd_en` shows up as `rd_data` moving during a hold. A stale or missing reset shows up as a non-zero `rd_data` right after reset.

// File: rtl/mla_pkg.sv
package mla_pkg;

    // Default geometry of the folded memory.
    localparam int DEF_NARROW_W     = 2;
    localparam int DEF_NARROW_DEPTH = 256;
    localparam int DEF_WIDE_W       = 8;

    // Number of narrow lanes carried by one wide row.
    function automatic int lane_count(input int narrow_w, input int wide_w);
        return wide_w / narrow_w;
    endfunction

    // Bits needed to index a lane (at least one).
    function automatic int lane_bits(input int narrow_w, input int wide_w);
        int n;
        n = $clog2(wide_w / narrow_w);
        return (n < 1) ? 1 : n;
    endfunction

endpackage

// File: rtl/mla_wr_fold.sv
module mla_wr_fold
    import mla_pkg::*;
#(
    parameter int NARROW_W = DEF_NARROW_W,
    parameter int WIDE_W   = DEF_WIDE_W,
    parameter int NADDR    = 8,
    localparam int LANES   = lane_count(NARROW_W, WIDE_W),
    localparam int LB      = lane_bits(NARROW_W, WIDE_W),
    localparam int RADDR   = NADDR - LB
) (
    input  logic                wr_clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [NADDR-1:0]    wr_addr,
    input  logic [NARROW_W-1:0] wr_data,
    output logic [RADDR-1:0]    wide_row,
    output logic [LANES-1:0]    wide_mask,
    output logic [WIDE_W-1:0]   wide_wdata
);

    typedef struct packed {
        logic [RADDR-1:0] row;
        logic [LB-1:0]    lane;
    } split_addr_t;

    split_addr_t sa;

    always_comb begin
        sa         = split_addr_t'(wr_addr);
        wide_row   = sa.row;
        wide_mask  = LANES'(1) << sa.lane;
        wide_wdata = WIDE_W'(wr_data) << (int'(sa.lane) * NARROW_W);
    end

    // One lane bit only, and it is the addressed lane.
    assert_onehot_mask_R2: assert property (@(posedge wr_clk) disable iff (rst)
        wr_en |-> ($countones(wide_mask) == 1 && wide_mask[wr_addr[LB-1:0]]));

    // Narrow data sits at the lane offset of the wide word.
    assert_lane_place_R3: assert property (@(posedge wr_clk) disable iff (rst)
        wr_en |-> (NARROW_W'(wide_wdata >> (int'(wr_addr[LB-1:0]) * NARROW_W)) == wr_data));

endmodule

// File: rtl/mla_wide_array.sv
module mla_wide_array
    import mla_pkg::*;
#(
    parameter int NARROW_W = DEF_NARROW_W,
    parameter int WIDE_W   = DEF_WIDE_W,
    parameter int RADDR    = 6,
    localparam int LANES   = lane_count(NARROW_W, WIDE_W),
    localparam int ROWS    = 1 << RADDR
) (
    input  logic                wr_clk,
    input  logic                wr_en,
    input  logic [RADDR-1:0]    wr_row,
    input  logic [LANES-1:0]    wr_mask,
    input  logic [WIDE_W-1:0]   wr_wdata,
    input  logic                rd_clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [RADDR-1:0]    rd_row,
    output logic [WIDE_W-1:0]   rd_wide
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [NARROW_W-1:0] store [ROWS];
        logic [NARROW_W-1:0] q;

        always_ff @(posedge wr_clk) begin
            if (wr_en && wr_mask[g])
                store[wr_row] <= wr_wdata[g*NARROW_W +: NARROW_W];
        end

        always_ff @(posedge rd_clk) begin
            if (rst)
                q <= '0;
            else if (rd_en)
                q <= store[rd_row];
        end

        assign rd_wide[g*NARROW_W +: NARROW_W] = q;
    end

    // Registered row only moves on a read.
    assert_rd_hold_R5: assert property (@(posedge rd_clk) disable iff (rst)
        !rd_en |=> $stable(rd_wide));

endmodule

// File: rtl/mla_rd_pick.sv
module mla_rd_pick
    import mla_pkg::*;
#(
    parameter int NARROW_W = DEF_NARROW_W,
    parameter int WIDE_W   = DEF_WIDE_W,
    localparam int LB      = lane_bits(NARROW_W, WIDE_W)
) (
    input  logic                rd_clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [LB-1:0]       rd_lane,
    input  logic [WIDE_W-1:0]   rd_wide,
    output logic [NARROW_W-1:0] rd_data
);

    logic [LB-1:0] lane_q;

    // Lane index travels with the row so it lines up with the late wide word.
    always_ff @(posedge rd_clk) begin
        if (rst)
            lane_q <= '0;
        else if (rd_en)
            lane_q <= rd_lane;
    end

    assign rd_data = rd_wide[int'(lane_q) * NARROW_W +: NARROW_W];

endmodule

// File: rtl/lane_fold_mem.sv
module lane_fold_mem
    import mla_pkg::*;
#(
    parameter int NARROW_W     = DEF_NARROW_W,
    parameter int NARROW_DEPTH = DEF_NARROW_DEPTH,
    parameter int WIDE_W       = DEF_WIDE_W,
    localparam int NADDR       = $clog2(NARROW_DEPTH),
    localparam int LANES       = lane_count(NARROW_W, WIDE_W),
    localparam int LB          = lane_bits(NARROW_W, WIDE_W),
    localparam int RADDR       = NADDR - LB
) (
    input  logic                wr_clk,
    input  logic                wr_en,
    input  logic [NADDR-1:0]    wr_addr,
    input  logic [NARROW_W-1:0] wr_data,
    input  logic                rd_clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [NADDR-1:0]    rd_addr,
    output logic [NARROW_W-1:0] rd_data
);

    logic [RADDR-1:0]  w_row;
    logic [LANES-1:0]  w_mask;
    logic [WIDE_W-1:0] w_wdata;
    logic [WIDE_W-1:0] r_wide;

    mla_wr_fold #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .NADDR(NADDR)) u_wr (
        .wr_clk     (wr_clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wide_row   (w_row),
        .wide_mask  (w_mask),
        .wide_wdata (w_wdata)
    );

    mla_wide_array #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .RADDR(RADDR)) u_arr (
        .wr_clk   (wr_clk),
        .wr_en    (wr_en),
        .wr_row   (w_row),
        .wr_mask  (w_mask),
        .wr_wdata (w_wdata),
        .rd_clk   (rd_clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_row   (rd_addr[NADDR-1:LB]),
        .rd_wide  (r_wide)
    );

    mla_rd_pick #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_rd (
        .rd_clk  (rd_clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_lane (rd_addr[LB-1:0]),
        .rd_wide (r_wide),
        .rd_data (rd_data)
    );

    // Output is cleared by the reset it just left.
    assert_reset_zero_R7: assert property (@(posedge rd_clk)
        $fell(rst) |-> (rd_data == '0));

endmodule

// File: tb/lane_fold_mem_tb.sv
module lane_fold_mem_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NW    = 2;
    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [NW-1:0] wr_data = '0;
    logic [NW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int model [DEPTH];
    int expd   = 0;
    string tag = "R7";

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_fold_mem u_dut (
        .wr_clk  (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_clk  (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    task automatic check_out();
        checks++;
        if (rd_data !== NW'(expd)) begin
            fails++;
            $display("FAIL %s: rd_data=%0d expected=%0d at %0t", tag, rd_data, expd, $time);
        end
    endtask

    // One cycle: drive at negedge, reference update at posedge, compare at next negedge.
    task automatic step(input logic we, input int wa, input int wd,
                        input logic re, input int ra);
        wr_en = we; wr_addr = AW'(wa); wr_data = NW'(wd);
        rd_en = re; rd_addr = AW'(ra);
        @(posedge clk);
        if (re) expd = model[ra];          // read sees pre-write value (R8)
        if (we) model[wa] = wd & 3;
        @(negedge clk);
        check_out();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R7";
        check_out();                       // R7: reset clears output

        // R1: fill every address with a value from its address bits
        tag = "R1";
        for (int a = 0; a < DEPTH; a++) step(1, a, (a ^ (a >> 2) ^ (a >> 5)) & 3, 0, 0);
        for (int a = 0; a < DEPTH; a++) step(0, 0, 0, 1, a);

        // R2 / R3: back-to-back writes to every lane of one row
        tag = "R2";
        for (int k = 0; k < 4; k++) step(1, 20 + k, 3 - k, 0, 0);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 20 + k);
        tag = "R3";
        step(1, 22, 1, 0, 0);
        step(0, 0, 0, 1, 22);
        step(0, 0, 0, 1, 21);
        step(0, 0, 0, 1, 23);

        // R6: writes with enable low change nothing
        tag = "R6";
        step(0, 40, (model[40] + 1) & 3, 0, 0);
        step(0, 41, (model[41] + 2) & 3, 0, 0);
        step(0, 0, 0, 1, 40);
        step(0, 0, 0, 1, 41);

        // R5: hold while rd_en low, address moves, held address rewritten
        tag = "R5";
        step(0, 0, 0, 1, 77);
        step(0, 0, 0, 0, 13);
        step(1, 77, (model[77] + 1) & 3, 0, 99);
        step(1, 76, (model[76] + 3) & 3, 0, 76);
        tag = "R4";
        step(0, 0, 0, 1, 77);

        // R8: same-edge read and write to one address
        tag = "R8";
        step(1, 150, (model[150] + 1) & 3, 1, 150);
        step(0, 0, 0, 1, 150);

        // R4: random interleaved traffic, concentrated on few rows
        tag = "R4";
        for (int n = 0; n < 3000; n++) begin
            automatic int ra = (n % 3 == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, DEPTH-1));
            automatic int wa = (n % 2 == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, DEPTH-1));
            step(logic'($urandom_range(0, 1)), wa, int'($urandom_range(0, 3)),
                 logic'($urandom_range(0, 1)), ra);
        end

        // R7: reset mid-run clears output, contents stay
        tag = "R7";
        rd_en = 1'b0; wr_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expd = 0;
        check_out();
        step(0, 0, 0, 1, 22);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule